// File: doc/BRIEF.md
# Flash Sector Erase Command Decoder

This block sits on the device side of a byte-wide flash write bus and watches every completed write. It recognises the six-write erase entry sequence: two key writes, an arm write, two more key writes and then a sector-erase command. Each sector-erase command selects the sector that its address points into. Once the sequence is complete, the block holds the selected sectors in a mask and opens an acceptance window. Further sector-erase commands may arrive inside that window. Each one adds its sector and starts the window over. Any other command inside the window throws the whole sequence away.

When the window runs out with no further write, the block pulses an erase-start strobe and enters an erase phase. The erase phase is modelled by a fixed cycle count. While it runs, a status bit reads 0 for any polled address inside a selected sector. When the count ends, the status bit reads 1 again and the block goes back to read mode. An abort command during the erase stops the erase at once and marks the affected sectors as holding undefined contents. A later erase of a sector that completes clears that sector's mark.

The window length comes from a clock-frequency parameter and a window length in microseconds. The erase length is a separate cycle-count parameter.

Top module: `fse_top`

## Requirements
- R1: A synchronous reset, whether applied at start-up or in the middle of a sequence, leaves erase_busy, erase_start and sect_mask at 0, clears sect_undef and sets stat_d7 to 1. No erase starts afterwards from the sequence that was under way.
- R2: The write sequence is as follows. First, address 0x0555 with data 0xAA. Next, 0x02AA with 0x55. Then 0x0555 with 0x80, 0x0555 with 0xAA and 0x02AA with 0x55. Last, data 0x30 at any address. After this sequence, sect_mask has exactly the bit set whose index is the top SECT_W bits of the address of the 0x30 write.
- R3: A wrong address or a wrong data value at any of the first five writes returns the decoder to read mode. A 0x30 write that follows then starts no erase and sect_mask stays 0.
- R4: A write's address is taken at the start of the strobe (bus_we_n falling). Its data is taken at the end of the strobe (bus_we_n rising).
- R5: erase_start is a single-cycle pulse. It is visible WIN_CYC+1 clock edges after the rising strobe edge of the last accepted 0x30 write is presented, where WIN_CYC = CLK_MHZ*WINDOW_US. Both erase_start and erase_busy go high on the same edge.
- R6: A 0x30 write inside the window ORs its sector into sect_mask and restarts the full window from the end of that write. Sectors may be added in any order.
- R7: Any data value other than 0x30 written inside the window returns the decoder to read mode with sect_mask cleared, and no erase starts.
- R8: erase_busy stays high for exactly ERASE_CYCLES clock cycles and sect_mask is non-zero throughout. Writes other than 0x F0 during the erase have no effect on the mask or on the duration.
- R9: stat_d7 is registered with one cycle of latency from bus_addr. It reads 0 only when erase_busy is high and bus_addr falls in a selected sector; otherwise it reads 1.
- R10: Writing data 0xF0 during the erase drops erase_busy and sect_mask on the next edge and ORs the mask into sect_undef. A completed erase clears the sect_undef bits of its sectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address; also the polled address for status reads |
| bus_data | input | 8 | Bus write data (command byte) |
| bus_we_n | input | 1 | Write strobe, active low |
| sect_mask | output | 2**SECT_W | Sectors selected for the pending or running erase |
| erase_start | output | 1 | One-cycle pulse when the erase begins |
| erase_busy | output | 1 | High while the modelled erase runs |
| stat_d7 | output | 1 | Status data bit: 0 while the polled sector is erasing |
| sect_undef | output | 2**SECT_W | Sectors whose contents were left undefined by an abort |

## Verification
A sweep runs a clean single-sector erase on every sector. This shows that the address-to-mask mapping, the start latency, the erase length and the status polarity hold for each index. It also shows that a polled address outside the selected sector keeps reading 1. Five runs each corrupt one step of the entry sequence, alternating between a wrong data value and a wrong address; this separates "the step was checked" from "only the count of writes matters". A strobe whose address and data both change while it is low shows which edge each is taken from. Two further cases cover the window: a late 0x30 write to a lower-numbered sector, and a foreign command inside the window. Together they tell a restarted window apart from a fixed one, and an extended buffer apart from a discarded one. An abort followed by a re-erase and a mid-window reset cover the undefined-sector flags and reset recovery.

// File: rtl/fse_pkg.sv
package fse_pkg;
  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_K1    = 3'd1,
    ST_K2    = 3'd2,
    ST_ARM   = 3'd3,
    ST_K3    = 3'd4,
    ST_K4    = 3'd5,
    ST_WIN   = 3'd6,
    ST_ERASE = 3'd7
  } fse_state_e;

  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_KEY1  = 8'hAA;
  localparam logic [CMD_W-1:0] CMD_KEY2  = 8'h55;
  localparam logic [CMD_W-1:0] CMD_ARM   = 8'h80;
  localparam logic [CMD_W-1:0] CMD_SECT  = 8'h30;
  localparam logic [CMD_W-1:0] CMD_ABORT = 8'hF0;
endpackage

// File: rtl/fse_strobe.sv
// Write strobe edge detection: the address is held from the falling edge,
// and a write event is flagged on the rising edge.
module fse_strobe #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b1;
      wr_addr <= '0;
    end else begin
      we_q <= we_n;
      if (we_q && !we_n) wr_addr <= addr;
    end
  end

  assign wr_evt = !we_q && we_n;
endmodule

// File: rtl/fse_downcnt.sv
// Loadable down counter; done fires on the LEN-th enabled cycle after load.
module fse_downcnt #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  output logic done
);
  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= CW'(LEN - 1);
    else if (en && cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign done = en && !load && (cnt == '0);
endmodule

// File: rtl/fse_ctrl.sv
// Command sequencer, sector buffer, acceptance window and erase phase.
module fse_ctrl
  import fse_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                SECT_W    = 3,
  parameter int                WIN_CYC   = 5000,
  parameter int                ERASE_CYC = 1000,
  parameter logic [ADDR_W-1:0] KEY_A     = ADDR_W'(16'h0555),
  parameter logic [ADDR_W-1:0] KEY_B     = ADDR_W'(16'h02AA),
  localparam int               NUM_SECT  = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_evt,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CMD_W-1:0]    wr_data,
  output logic [NUM_SECT-1:0] mask_o,
  output logic                start_o,
  output logic                busy_o,
  output logic [NUM_SECT-1:0] undef_o
);
  fse_state_e          state_q, state_d;
  logic [NUM_SECT-1:0] mask_d, undef_d, sel;
  logic                start_d;
  logic                hit_a, hit_b;
  logic                win_load, win_en, win_done, er_en, er_done;

  assign sel   = NUM_SECT'(1) << wr_addr[ADDR_W-1 -: SECT_W];
  assign hit_a = (wr_addr == KEY_A);
  assign hit_b = (wr_addr == KEY_B);

  assign win_load = wr_evt && (wr_data == CMD_SECT) &&
                    (state_q == ST_K4 || state_q == ST_WIN);
  assign win_en   = (state_q == ST_WIN) && !wr_evt;
  assign er_en    = (state_q == ST_ERASE);

  fse_downcnt #(.LEN(WIN_CYC)) win_cnt_i (
    .clk(clk), .rst(rst), .load(win_load), .en(win_en), .done(win_done)
  );

  fse_downcnt #(.LEN(ERASE_CYC)) er_cnt_i (
    .clk(clk), .rst(rst), .load(start_d), .en(er_en), .done(er_done)
  );

  always_comb begin
    state_d = state_q;
    mask_d  = mask_o;
    undef_d = undef_o;
    start_d = 1'b0;
    case (state_q)
      ST_READ:
        if (wr_evt && hit_a && wr_data == CMD_KEY1) state_d = ST_K1;
      ST_K1:
        if (wr_evt) state_d = (hit_b && wr_data == CMD_KEY2) ? ST_K2 : ST_READ;
      ST_K2:
        if (wr_evt) state_d = (hit_a && wr_data == CMD_ARM) ? ST_ARM : ST_READ;
      ST_ARM:
        if (wr_evt) state_d = (hit_a && wr_data == CMD_KEY1) ? ST_K3 : ST_READ;
      ST_K3:
        if (wr_evt) state_d = (hit_b && wr_data == CMD_KEY2) ? ST_K4 : ST_READ;
      ST_K4:
        if (wr_evt) begin
          if (wr_data == CMD_SECT) begin
            state_d = ST_WIN;
            mask_d  = sel;
          end else begin
            state_d = ST_READ;
          end
        end
      ST_WIN:
        if (wr_evt) begin
          if (wr_data == CMD_SECT) begin
            mask_d = mask_o | sel;
          end else begin
            state_d = ST_READ;
            mask_d  = '0;
          end
        end else if (win_done) begin
          state_d = ST_ERASE;
          start_d = 1'b1;
        end
      ST_ERASE:
        if (wr_evt && wr_data == CMD_ABORT) begin
          state_d = ST_READ;
          undef_d = undef_o | mask_o;
          mask_d  = '0;
        end else if (er_done) begin
          state_d = ST_READ;
          undef_d = undef_o & ~mask_o;
          mask_d  = '0;
        end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_READ;
      mask_o  <= '0;
      undef_o <= '0;
      start_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_o  <= mask_d;
      undef_o <= undef_d;
      start_o <= start_d;
      busy_o  <= (state_d == ST_ERASE);
    end
  end
endmodule

// File: rtl/fse_top.sv
// Sector erase command decoder: top level with status bit readback.
module fse_top
  import fse_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter int                SECT_W       = 3,
  parameter int                CLK_MHZ      = 100,
  parameter int                WINDOW_US    = 50,
  parameter int                ERASE_CYCLES = 1000,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A   = ADDR_W'(16'h0555),
  parameter logic [ADDR_W-1:0] KEY_ADDR_B   = ADDR_W'(16'h02AA),
  localparam int               NUM_SECT     = 1 << SECT_W,
  localparam int               WIN_CYC      = CLK_MHZ * WINDOW_US
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CMD_W-1:0]    bus_data,
  input  logic                bus_we_n,
  output logic [NUM_SECT-1:0] sect_mask,
  output logic                erase_start,
  output logic                erase_busy,
  output logic                stat_d7,
  output logic [NUM_SECT-1:0] sect_undef
);
  logic              wr_evt;
  logic [ADDR_W-1:0] wr_addr;

  fse_strobe #(.ADDR_W(ADDR_W)) strobe_i (
    .clk(clk), .rst(rst), .we_n(bus_we_n), .addr(bus_addr),
    .wr_evt(wr_evt), .wr_addr(wr_addr)
  );

  fse_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .WIN_CYC(WIN_CYC),
    .ERASE_CYC(ERASE_CYCLES), .KEY_A(KEY_ADDR_A), .KEY_B(KEY_ADDR_B)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(bus_data), .mask_o(sect_mask), .start_o(erase_start),
    .busy_o(erase_busy), .undef_o(sect_undef)
  );

  always_ff @(posedge clk) begin
    if (rst) stat_d7 <= 1'b1;
    else     stat_d7 <= !(erase_busy && sect_mask[bus_addr[ADDR_W-1 -: SECT_W]]);
  end
endmodule

// File: rtl/fse_chk.sv
module fse_chk #(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                erase_start,
  input logic                erase_busy,
  input logic                stat_d7,
  input logic [NUM_SECT-1:0] sect_mask,
  input logic [NUM_SECT-1:0] sect_undef
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!erase_busy && sect_mask == '0 && sect_undef == '0 && stat_d7));

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);

  // R5
  busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_busy) |-> erase_start);

  // R8
  busy_mask_chk: assert property (@(posedge clk) disable iff (rst)
    erase_busy |-> (sect_mask != '0));

  // R9
  d7_low_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_d7 |-> $past(erase_busy));

  // R10
  undef_grow_chk: assert property (@(posedge clk) disable iff (rst)
    ((sect_undef & ~$past(sect_undef)) != '0) |-> ($past(erase_busy) && !erase_busy));
endmodule

bind fse_top fse_chk #(.NUM_SECT(NUM_SECT)) chk_i (
  .clk(clk), .rst(rst), .erase_start(erase_start), .erase_busy(erase_busy),
  .stat_d7(stat_d7), .sect_mask(sect_mask), .sect_undef(sect_undef)
);

// File: tb/fse_top_tb_top.sv
module fse_top_tb_top;
  localparam int W  = 20;
  localparam int EC = 30;
  localparam logic [15:0] KA = 16'h0555;
  localparam logic [15:0] KB = 16'h02AA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_we_n = 1'b1;
  logic [7:0]  sect_mask, sect_undef;
  logic        erase_start, erase_busy, stat_d7;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fse_top #(.ADDR_W(16), .SECT_W(3), .CLK_MHZ(1), .WINDOW_US(W), .ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data), .bus_we_n(bus_we_n),
    .sect_mask(sect_mask), .erase_start(erase_start), .erase_busy(erase_busy),
    .stat_d7(stat_d7), .sect_undef(sect_undef)
  );

  function automatic logic [15:0] sa(input int s);
    return {3'(s), 13'h0123};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] af, input logic [15:0] ar,
                        input logic [7:0] df, input logic [7:0] dr);
    @(negedge clk); bus_addr = af; bus_data = df; bus_we_n = 1'b0;
    @(negedge clk); bus_addr = ar; bus_data = dr;
    @(negedge clk); bus_we_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_wr(a, a, d, d);
  endtask

  // five entry writes; step bad (0..4) is corrupted, -1 for none
  task automatic unlock5(input int bad);
    logic [15:0] a;
    logic [7:0]  d;
    for (int st = 0; st < 5; st++) begin
      case (st)
        0: begin a = KA; d = 8'hAA; end
        1: begin a = KB; d = 8'h55; end
        2: begin a = KA; d = 8'h80; end
        3: begin a = KA; d = 8'hAA; end
        default: begin a = KB; d = 8'h55; end
      endcase
      if (st == bad) begin
        if (st % 2 == 0) d = d ^ 8'h01;
        else             a = a ^ 16'h0001;
      end
      wr(a, d);
    end
  endtask

  task automatic wait_start(input int c0, output int lat);
    lat = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (erase_start) begin
        lat = cyc - c0;
        break;
      end
    end
  endtask

  task automatic no_start(input string req);
    int seen = 0;
    for (int i = 0; i < W + 5; i++) begin
      @(negedge clk);
      if (erase_start) seen = 1;
    end
    chk(req, seen, 0);
  endtask

  task automatic finish_erase(input string req);
    int t0 = cyc;
    while (erase_busy) @(negedge clk);
    chk(req, cyc - t0, EC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog cycles=%0d expected<100000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0, lat;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", erase_busy, 0);
    chk("R1 mask", sect_mask, 0);
    chk("R1 start", erase_start, 0);
    chk("R1 undef", sect_undef, 0);
    chk("R1 d7", stat_d7, 1);

    // R2 R5 R8 R9 sweep over all sectors
    for (int s = 0; s < 8; s++) begin
      unlock5(-1);
      wr(sa(s), 8'h30);
      c0 = cyc;
      wait_start(c0, lat);
      chk("R5 latency", lat, W + 1);
      chk("R2 mask", sect_mask, 1 << s);
      chk("R8 busy", erase_busy, 1);
      c0 = cyc;
      bus_addr = sa(s);
      @(negedge clk);
      chk("R5 pulse", erase_start, 0);
      @(negedge clk);
      chk("R9 d7 selected", stat_d7, 0);
      bus_addr = sa((s + 1) % 8);
      repeat (2) @(negedge clk);
      chk("R9 d7 other", stat_d7, 1);
      if (s == 2) begin
        wr(sa(5), 8'h30);
        @(negedge clk);
        chk("R8 ignored mask", sect_mask, 8'h04);
        chk("R8 ignored busy", erase_busy, 1);
      end
      while (erase_busy) @(negedge clk);
      chk("R8 duration", cyc - c0, EC);
      bus_addr = sa(s);
      repeat (2) @(negedge clk);
      chk("R9 d7 done", stat_d7, 1);
      chk("R2 mask cleared", sect_mask, 0);
    end

    // R3 corrupt each entry step
    for (int k = 0; k < 5; k++) begin
      unlock5(k);
      wr(sa(3), 8'h30);
      no_start("R3 no start");
      chk("R3 mask", sect_mask, 0);
    end

    // R4 address at falling edge, data at rising edge
    unlock5(-1);
    bus_wr(sa(3), sa(6), 8'h00, 8'h30);
    c0 = cyc;
    repeat (2) @(negedge clk);
    chk("R4 mask", sect_mask, 8'h08);
    wait_start(c0, lat);
    chk("R4 latency", lat, W + 1);
    finish_erase("R4 duration");

    // R6 window restart and buffer extension, descending order
    unlock5(-1);
    wr(sa(6), 8'h30);
    repeat (10) @(negedge clk);
    wr(sa(0), 8'h30);
    c0 = cyc;
    wait_start(c0, lat);
    chk("R6 latency", lat, W + 1);
    chk("R6 mask", sect_mask, 8'h41);
    finish_erase("R6 duration");

    // R7 foreign command inside window
    unlock5(-1);
    wr(sa(4), 8'h30);
    repeat (5) @(negedge clk);
    wr(sa(4), 8'hAA);
    repeat (2) @(negedge clk);
    chk("R7 mask", sect_mask, 0);
    no_start("R7 no start");

    // R10 abort, then re-erase one sector
    unlock5(-1);
    wr(sa(2), 8'h30);
    wr(sa(7), 8'h30);
    c0 = cyc;
    wait_start(c0, lat);
    chk("R10 started", lat, W + 1);
    repeat (4) @(negedge clk);
    wr(16'h0000, 8'hF0);
    repeat (2) @(negedge clk);
    chk("R10 busy", erase_busy, 0);
    chk("R10 mask", sect_mask, 0);
    chk("R10 undef set", sect_undef, 8'h84);
    unlock5(-1);
    wr(sa(7), 8'h30);
    c0 = cyc;
    wait_start(c0, lat);
    finish_erase("R10 re-erase duration");
    @(negedge clk);
    chk("R10 undef cleared", sect_undef, 8'h04);

    // R1 reset in the middle of a window
    unlock5(-1);
    wr(sa(1), 8'h30);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 mid mask", sect_mask, 0);
    chk("R1 mid undef", sect_undef, 0);
    no_start("R1 mid no start");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule